// File: doc/BRIEF.md
# Grant-Gated Output Queue Admission and Transmit Selector

This block governs entry into and exit from a set of output queues, one queue per output port and per priority level, for a packet switch. It keeps only an occupancy count for each queue; payload storage lives elsewhere. Each incoming descriptor names a destination port and a priority, and carries three flags: data, active and backup. A per-port receive grant vector decides whether a descriptor may join its queue. Descriptors that are outside the gated class bypass that decision.

Transmission is decided once per packet slot. A slot-start strobe triggers one decision for every port, and all ports are decided in parallel. A port whose send grant is high and that holds waiting descriptors sends from its most urgent non-empty priority. Priority 0 is the most urgent. Any other port emits an idle packet in that slot.

Top module: `grant_queue_ctrl`

## Requirements
- R1: Every cycle with `inValid` high produces, on the next cycle, exactly one of `enqAccept`, `enqBlocked` or `enqDropFull`. A cycle with `inValid` low produces none of them.
- R2: A descriptor is gated when `inIsData`=1, `inActive`=1 and `inBackup`=0. A gated descriptor for port n with `rcvGrant[n]`=0 raises `enqBlocked` and leaves every queue unchanged.
- R3: A descriptor that is not gated ignores `rcvGrant`. It is accepted whenever its queue is not full.
- R4: Each queue holds at most `QUEUE_DEPTH` descriptors (8 by default). A descriptor for a full queue raises `enqDropFull` and leaves the count unchanged.
- R5: `txValid` is high for exactly the one cycle after each cycle with `slotStart` high. When `txValid` is low, `txSend` is all zero.
- R6: In a slot, a port n with `sndGrant[n]`=0 has `txSend[n]`=0, which means an idle packet. Its queues are unchanged.
- R7: In a slot, a port n with `sndGrant[n]`=1 and any non-empty queue has `txSend[n]`=1. `txPrio[2n+1:2n]` then gives the lowest-numbered non-empty priority, and that queue loses one descriptor.
- R8: In a slot, a port with `sndGrant` high but all four queues empty emits an idle packet (`txSend[n]`=0).
- R9: An enqueue and a dequeue may hit the same queue in one cycle, and both take effect. Fullness for admission is judged on the count before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; all queues empty |
| inValid | input | 1 | Incoming descriptor present |
| inDest | input | 4 | Destination port |
| inPrio | input | 2 | Priority, 0 most urgent |
| inIsData | input | 1 | Descriptor is a data packet |
| inActive | input | 1 | Active flag |
| inBackup | input | 1 | Backup flag |
| rcvGrant | input | 16 | Per-port receive grant |
| sndGrant | input | 16 | Per-port send grant |
| slotStart | input | 1 | Packet-slot strobe; starts a transmit decision |
| enqAccept | output | 1 | Descriptor enqueued (registered) |
| enqBlocked | output | 1 | Refused by receive grant (registered) |
| enqDropFull | output | 1 | Refused because the queue is full (registered) |
| txValid | output | 1 | Transmit decision valid this cycle |
| txSend | output | 16 | Per-port data send; 0 means idle |
| txPrio | output | 32 | Per-port chosen priority, 2 bits per port |

## Verification
The only state in this block is the occupancy counts, so a miscount shows up at the ports in one of two ways. The first is a descriptor that is refused or accepted against the bench's own running count of that queue, which appears on the cycle after the offending input. The second is a transmit decision that names the wrong priority, or sends from a queue the bench believes empty. That appears on the first slot after the count goes wrong, provided the port is granted. The long random run keeps queues filling and draining on all ports, so a corrupted count cannot stay hidden for long.

// File: rtl/gq_pkg.sv
package gq_pkg;
  localparam int NUM_PORTS = 16;
  localparam int NUM_PRIO  = 4;
  localparam int PORT_W    = $clog2(NUM_PORTS);
  localparam int PRIO_W    = $clog2(NUM_PRIO);

  // strobes from control to datapath
  typedef struct packed {
    logic                               enq;
    logic                               blocked;
    logic                               dropFull;
    logic [PORT_W-1:0]                  port;
    logic [PRIO_W-1:0]                  prio;
    logic                               slot;
    logic [NUM_PORTS-1:0]               deq;
    logic [NUM_PORTS-1:0][PRIO_W-1:0]   deqPrio;
  } gqStrobes_t;
endpackage

// File: rtl/gq_control.sv
module gq_control
  import gq_pkg::*;
(
  input  logic                                   inValid,
  input  logic [PORT_W-1:0]                      inDest,
  input  logic [PRIO_W-1:0]                      inPrio,
  input  logic                                   inIsData,
  input  logic                                   inActive,
  input  logic                                   inBackup,
  input  logic [NUM_PORTS-1:0]                   rcvGrant,
  input  logic [NUM_PORTS-1:0]                   sndGrant,
  input  logic                                   slotStart,
  input  logic [NUM_PORTS-1:0][NUM_PRIO-1:0]     queueFull,
  input  logic [NUM_PORTS-1:0][NUM_PRIO-1:0]     queueNonEmpty,
  output gqStrobes_t                             strb
);
  logic gated;
  logic grantOk;
  logic destFull;

  always_comb begin
    gated    = inIsData && inActive && !inBackup;
    grantOk  = !gated || rcvGrant[inDest];
    destFull = queueFull[inDest][inPrio];

    strb.enq      = inValid && grantOk && !destFull;
    strb.blocked  = inValid && !grantOk;
    strb.dropFull = inValid && grantOk && destFull;
    strb.port     = inDest;
    strb.prio     = inPrio;
    strb.slot     = slotStart;
  end

  // per-port pick: lowest-numbered non-empty priority wins
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pick
    always_comb begin
      strb.deqPrio[p] = '0;
      for (int q = NUM_PRIO - 1; q >= 0; q--) begin
        if (queueNonEmpty[p][q]) strb.deqPrio[p] = PRIO_W'(q);
      end
      strb.deq[p] = slotStart && sndGrant[p] && (|queueNonEmpty[p]);
    end
  end
endmodule

// File: rtl/gq_datapath.sv
module gq_datapath
  import gq_pkg::*;
#(
  parameter int QUEUE_DEPTH = 8
)(
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  gqStrobes_t                             strb,
  output logic [NUM_PORTS-1:0][NUM_PRIO-1:0]     queueFull,
  output logic [NUM_PORTS-1:0][NUM_PRIO-1:0]     queueNonEmpty,
  output logic                                   enqAccept,
  output logic                                   enqBlocked,
  output logic                                   enqDropFull,
  output logic                                   txValid,
  output logic [NUM_PORTS-1:0]                   txSend,
  output logic [NUM_PORTS*PRIO_W-1:0]            txPrio
);
  localparam int CNT_W = $clog2(QUEUE_DEPTH + 1);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    for (genvar q = 0; q < NUM_PRIO; q++) begin : g_prio
      logic [CNT_W-1:0] count;
      logic             inc;
      logic             dec;

      assign inc = strb.enq && (strb.port == PORT_W'(p)) && (strb.prio == PRIO_W'(q));
      assign dec = strb.deq[p] && (strb.deqPrio[p] == PRIO_W'(q));

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          count <= '0;
        end else begin
          case ({inc, dec})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
          endcase
        end
      end

      assign queueFull[p][q]     = (count == CNT_W'(QUEUE_DEPTH));
      assign queueNonEmpty[p][q] = (count != '0);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        txSend[p]                   <= 1'b0;
        txPrio[p*PRIO_W +: PRIO_W]  <= '0;
      end else begin
        txSend[p]                   <= strb.deq[p];
        txPrio[p*PRIO_W +: PRIO_W]  <= strb.deq[p] ? strb.deqPrio[p] : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enqAccept   <= 1'b0;
      enqBlocked  <= 1'b0;
      enqDropFull <= 1'b0;
      txValid     <= 1'b0;
    end else begin
      enqAccept   <= strb.enq;
      enqBlocked  <= strb.blocked;
      enqDropFull <= strb.dropFull;
      txValid     <= strb.slot;
    end
  end
endmodule

// File: rtl/grant_queue_ctrl.sv
module grant_queue_ctrl
  import gq_pkg::*;
#(
  parameter int QUEUE_DEPTH = 8
)(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         inValid,
  input  logic [PORT_W-1:0]            inDest,
  input  logic [PRIO_W-1:0]            inPrio,
  input  logic                         inIsData,
  input  logic                         inActive,
  input  logic                         inBackup,
  input  logic [NUM_PORTS-1:0]         rcvGrant,
  input  logic [NUM_PORTS-1:0]         sndGrant,
  input  logic                         slotStart,
  output logic                         enqAccept,
  output logic                         enqBlocked,
  output logic                         enqDropFull,
  output logic                         txValid,
  output logic [NUM_PORTS-1:0]         txSend,
  output logic [NUM_PORTS*PRIO_W-1:0]  txPrio
);
  gqStrobes_t                           strb;
  logic [NUM_PORTS-1:0][NUM_PRIO-1:0]   queueFull;
  logic [NUM_PORTS-1:0][NUM_PRIO-1:0]   queueNonEmpty;

  gq_control u_ctrl (
    .inValid       (inValid),
    .inDest        (inDest),
    .inPrio        (inPrio),
    .inIsData      (inIsData),
    .inActive      (inActive),
    .inBackup      (inBackup),
    .rcvGrant      (rcvGrant),
    .sndGrant      (sndGrant),
    .slotStart     (slotStart),
    .queueFull     (queueFull),
    .queueNonEmpty (queueNonEmpty),
    .strb          (strb)
  );

  gq_datapath #(.QUEUE_DEPTH(QUEUE_DEPTH)) u_dp (
    .clk           (clk),
    .rst_n         (rst_n),
    .strb          (strb),
    .queueFull     (queueFull),
    .queueNonEmpty (queueNonEmpty),
    .enqAccept     (enqAccept),
    .enqBlocked    (enqBlocked),
    .enqDropFull   (enqDropFull),
    .txValid       (txValid),
    .txSend        (txSend),
    .txPrio        (txPrio)
  );
endmodule

// File: rtl/gq_checker.sv
module gq_checker
  import gq_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 inValid,
  input logic [PORT_W-1:0]    inDest,
  input logic                 inIsData,
  input logic                 inActive,
  input logic                 inBackup,
  input logic [NUM_PORTS-1:0] rcvGrant,
  input logic [NUM_PORTS-1:0] sndGrant,
  input logic                 slotStart,
  input logic                 enqAccept,
  input logic                 enqBlocked,
  input logic                 enqDropFull,
  input logic                 txValid,
  input logic [NUM_PORTS-1:0] txSend
);
  assert_one_outcome_R1: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> $onehot({enqAccept, enqBlocked, enqDropFull}));

  assert_no_outcome_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !(enqAccept || enqBlocked || enqDropFull));

  assert_gate_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inIsData && inActive && !inBackup && !rcvGrant[inDest]) |=> enqBlocked);

  assert_bypass_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && !(inIsData && inActive && !inBackup)) |=> !enqBlocked);

  assert_slot_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    slotStart |=> txValid);

  assert_no_slot_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !slotStart |=> (!txValid && txSend == '0));

  assert_idle_ungranted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slotStart |=> ((txSend & ~$past(sndGrant)) == '0));
endmodule

bind grant_queue_ctrl gq_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .inValid     (inValid),
  .inDest      (inDest),
  .inIsData    (inIsData),
  .inActive    (inActive),
  .inBackup    (inBackup),
  .rcvGrant    (rcvGrant),
  .sndGrant    (sndGrant),
  .slotStart   (slotStart),
  .enqAccept   (enqAccept),
  .enqBlocked  (enqBlocked),
  .enqDropFull (enqDropFull),
  .txValid     (txValid),
  .txSend      (txSend)
);

// File: tb/tb_grant_queue_ctrl.sv
module tb_grant_queue_ctrl;
  localparam int NP = 16;
  localparam int NQ = 4;
  localparam int DEPTH = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic inValid = 0;
  logic [3:0] inDest = 0;
  logic [1:0] inPrio = 0;
  logic inIsData = 0, inActive = 0, inBackup = 0;
  logic [NP-1:0] rcvGrant = 0, sndGrant = 0;
  logic slotStart = 0;
  logic enqAccept, enqBlocked, enqDropFull, txValid;
  logic [NP-1:0] txSend;
  logic [2*NP-1:0] txPrio;

  int checks = 0;
  int errors = 0;
  int model [NP][NQ];

  always #5 clk = ~clk;

  grant_queue_ctrl #(.QUEUE_DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inDest(inDest), .inPrio(inPrio),
    .inIsData(inIsData), .inActive(inActive), .inBackup(inBackup),
    .rcvGrant(rcvGrant), .sndGrant(sndGrant), .slotStart(slotStart),
    .enqAccept(enqAccept), .enqBlocked(enqBlocked), .enqDropFull(enqDropFull),
    .txValid(txValid), .txSend(txSend), .txPrio(txPrio)
  );

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int firstBusy(int p);
    for (int q = 0; q < NQ; q++) if (model[p][q] > 0) return q;
    return -1;
  endfunction

  // one clock: predict from model and inputs, advance model, compare outputs
  task automatic cycle(string tag);
    logic [2:0] expOut;
    logic [NP-1:0] expSend;
    logic [2*NP-1:0] expPrio;
    bit gated, gOk, full;
    string oTag, tTag;
    gated = inIsData && inActive && !inBackup;
    gOk = !gated || rcvGrant[inDest];
    full = model[inDest][inPrio] >= DEPTH;
    expOut = 3'b000;
    oTag = "R1";
    if (inValid) begin
      if (!gOk) begin expOut = 3'b010; oTag = "R2"; end
      else if (full) begin expOut = 3'b001; oTag = "R4"; end
      else begin expOut = 3'b100; oTag = gated ? "R1" : "R3"; end
    end
    expSend = '0; expPrio = '0; tTag = "R5";
    if (slotStart) begin
      for (int p = 0; p < NP; p++) begin
        int b;
        b = firstBusy(p);
        if (sndGrant[p] && b >= 0) begin
          expSend[p] = 1'b1;
          expPrio[2*p +: 2] = 2'(b);
          model[p][b]--;
          tTag = "R7";
        end
      end
    end
    if (expOut[2]) model[inDest][inPrio]++;
    @(posedge clk); #1;
    check({enqAccept, enqBlocked, enqDropFull} == expOut, {tag, " ", oTag, " outcome"},
          {enqAccept, enqBlocked, enqDropFull}, expOut);
    check(txValid == slotStart, {tag, " R5 txValid"}, txValid, slotStart);
    check(txSend == expSend, {tag, " ", tTag, " R6 R8 txSend"}, txSend, expSend);
    check(txPrio == expPrio, {tag, " R7 txPrio"}, txPrio, expPrio);
    @(negedge clk);
  endtask

  task automatic drive(bit v, int d, int pr, bit dt, bit ac, bit bk, bit sl);
    inValid = v; inDest = 4'(d); inPrio = 2'(pr);
    inIsData = dt; inActive = ac; inBackup = bk; slotStart = sl;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int p = 0; p < NP; p++) for (int q = 0; q < NQ; q++) model[p][q] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    #1;
    check({enqAccept, enqBlocked, enqDropFull, txValid} == 4'b0, "reset R1 R5", 0, 0);
    check(txSend == '0, "reset R5 txSend", txSend, 0);

    // R4: fill port 3 priority 2 past its depth with gated packets, grant high
    rcvGrant = '1; sndGrant = '0;
    for (int i = 0; i < DEPTH + 2; i++) begin
      drive(1, 3, 2, 1, 1, 0, 0);
      cycle("fill_R4");
    end
    // R2: gated packet, grant low
    rcvGrant = '1; rcvGrant[5] = 1'b0;
    drive(1, 5, 0, 1, 1, 0, 0); cycle("gate_R2");
    // R3: backup flag set bypasses the gate
    drive(1, 5, 1, 1, 1, 1, 0); cycle("bypass_R3");
    drive(1, 5, 0, 0, 1, 0, 0); cycle("ctrl_R3");
    // R6: slot with send grant low for port 3
    drive(0, 0, 0, 0, 0, 0, 1); cycle("ungranted_R6");
    // R8: granted empty ports idle, port 3 sends priority 2
    sndGrant = '1;
    drive(0, 0, 0, 0, 0, 0, 1); cycle("slot_R7_R8");
    // R9: refill to full, then enqueue and dequeue the same queue together
    drive(1, 3, 2, 1, 1, 0, 0); cycle("refill_R4");
    sndGrant = '0; sndGrant[3] = 1'b1;
    drive(1, 3, 2, 1, 1, 0, 1); cycle("same_edge_R9");
    // R7: urgent priority overtakes
    drive(1, 3, 0, 0, 0, 0, 0); cycle("urgent_R7");
    drive(0, 0, 0, 0, 0, 0, 1); cycle("pick0_R7");
    drive(0, 0, 0, 0, 0, 0, 1); cycle("pick2_R7");

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      rcvGrant = NP'($urandom);
      sndGrant = NP'($urandom) | NP'($urandom);
      drive(($urandom % 10) < 8, $urandom % NP, $urandom % NQ,
            ($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 4) == 0,
            ($urandom % 4) == 0);
      if (n % 16 < 4) inDest = 4'($urandom % 2);
      cycle("random");
    end
    drive(0, 0, 0, 0, 0, 0, 0); cycle("tail_R5");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule